// File: doc/BRIEF.md
# Packed Interrupt Priority Array Port

This block holds a table of 64 eight-bit interrupt priorities and lets a register-access path reach them as machine words. A caller presents a select value, a width mode (32-bit or 64-bit words), write data and a write mask in a single cycle. In that same cycle the block returns the packed word built from the current priorities and an error flag. At the next clock edge it stores the mask-merged word back into the table, one byte per priority entry.

Sixteen consecutive select values form the legal window. With 32-bit words each select reaches four entries. With 64-bit words only even selects are legal, and each one reaches eight entries. One entry, the external-interrupt source of the privilege level that owns this table, is set by a parameter. That entry can never be written and always reads as zero. Deciding which register address reached the block is left to the caller.

Top module: `prio_array_port`

## Requirements
- R1: After reset every priority entry reads as zero through every legal select in both width modes.
- R2: A select below `SEL_BASE` (default 0x30) or above `SEL_BASE`+15 (default 0x3F) raises `accessErr` in the cycle it is presented.
- R3: When `wideMode` is 1, an odd select raises `accessErr`. When `wideMode` is 0, every select inside the window is legal.
- R4: When `wideMode` is 0, the select at offset k from `SEL_BASE` reaches entries 4k to 4k+3. Entry 4k+i appears in `rdData` bits [8i+7:8i].
- R5: When `wideMode` is 1, the select at even offset k reaches entries 4k to 4k+7, which is (k/2)*8 onward. Entry 4k+i appears in bits [8i+7:8i].
- R6: A legal access returns the old word in its own cycle. At the next edge each reached entry becomes (old & ~mask) | (data & mask) over its byte lane. The new value is visible from the following cycle.
- R7: Entry `EXT_ENTRY` (default 11) ignores every write and always reads as zero.
- R8: When `wideMode` is 0, `rdData[63:32]` is zero, and `wrData`/`wrMask` bits 63:32 have no effect on any entry.
- R9: When `accessErr` is 1, `rdData` is zero and no entry changes.
- R10: While `accessEn` is 0, `rdData` is zero, `accessErr` is 0 and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accessEn | input | 1 | An access is presented this cycle |
| selIdx | input | 12 | Word select value |
| wideMode | input | 1 | 1 = 64-bit words, 0 = 32-bit words |
| wrData | input | 64 | Data merged into the reached entries |
| wrMask | input | 64 | Bits of wrData that take effect |
| rdData | output | 64 | Packed old word of the reached entries |
| accessErr | output | 1 | The presented select is illegal |

## Verification
Four behaviours are checked by assertions on every cycle. A flagged access must read zero. A 32-bit access must leave the upper half clear. An idle cycle must return zero and raise no error. Any cycle without a write strobe must leave the whole table unchanged. Only the bench's scenarios can show the rest: the select-to-entry mapping in each mode, byte merging under partial masks, the read-only external entry, and a table that survives illegal accesses. The bench shows these by comparing every access with a behavioural model of the table and reading words back across both modes.

// File: rtl/prio_port_pkg.sv
package prio_port_pkg;
  localparam int ENTRY_W     = 8;
  localparam int NUM_ENTRIES = 64;
  localparam int WORD_W      = 64;
  localparam int IDX_W       = $clog2(NUM_ENTRIES);
  localparam int LANES_WIDE  = WORD_W / ENTRY_W;
  localparam int LANES_NARROW = LANES_WIDE / 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic             wide;
    logic [IDX_W-1:0] firstEntry;
  } prio_strobe_t;
endpackage

// File: rtl/prio_port_ctrl.sv
module prio_port_ctrl
  import prio_port_pkg::*;
#(
  parameter int SEL_W     = 12,
  parameter int SEL_BASE  = 'h30,
  parameter int NUM_WORDS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accessEn,
  input  logic [SEL_W-1:0] selIdx,
  input  logic             wideMode,
  output logic             accessErr,
  output prio_strobe_t     strobe
);
  localparam logic [SEL_W-1:0] SEL_FIRST = SEL_W'(SEL_BASE);
  localparam logic [SEL_W-1:0] SEL_LAST  = SEL_W'(SEL_BASE + NUM_WORDS - 1);

  logic [SEL_W-1:0] selOffset;
  logic             inWindow;
  logic             oddWide;
  logic             legal;

  always_comb begin
    selOffset = selIdx - SEL_FIRST;
    inWindow  = (selIdx >= SEL_FIRST) && (selIdx <= SEL_LAST);
    oddWide   = wideMode && selIdx[0];
    legal     = accessEn && inWindow && !oddWide;
    accessErr = accessEn && !legal;
    strobe.rdEn       = legal;
    strobe.wrEn       = legal;
    strobe.wide       = wideMode;
    strobe.firstEntry = IDX_W'(selOffset * SEL_W'(LANES_NARROW));
  end

  // R3: odd select in wide mode is never accepted
  assert_wide_odd_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accessEn && wideMode && selIdx[0]) |-> (accessErr && !strobe.wrEn));
endmodule

// File: rtl/prio_port_dp.sv
module prio_port_dp
  import prio_port_pkg::*;
#(
  parameter int EXT_ENTRY = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  prio_strobe_t        strobe,
  input  logic [WORD_W-1:0]   wrData,
  input  logic [WORD_W-1:0]   wrMask,
  output logic [WORD_W-1:0]   rdData
);
  localparam int NARROW_SH = $clog2(LANES_NARROW);
  localparam int WIDE_SH   = $clog2(LANES_WIDE);

  logic [ENTRY_W-1:0]             prioMem [NUM_ENTRIES];
  logic [NUM_ENTRIES*ENTRY_W-1:0] memFlat;
  logic [WORD_W-1:0]              effData;
  logic [WORD_W-1:0]              effMask;

  always_comb begin
    effData = strobe.wide ? wrData : {{(WORD_W/2){1'b0}}, wrData[WORD_W/2-1:0]};
    effMask = strobe.wide ? wrMask : {{(WORD_W/2){1'b0}}, wrMask[WORD_W/2-1:0]};
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic [ENTRY_W-1:0] entryQ;
    if (e == EXT_ENTRY) begin : g_fixed
      assign entryQ = '0;
    end else begin : g_store
      localparam int LANE_N = e % LANES_NARROW;
      localparam int LANE_W = e % LANES_WIDE;
      logic               hit;
      logic [ENTRY_W-1:0] laneData;
      logic [ENTRY_W-1:0] laneMask;
      always_comb begin
        if (strobe.wide) begin
          hit      = (strobe.firstEntry >> WIDE_SH) == IDX_W'(e >> WIDE_SH);
          laneData = effData[LANE_W*ENTRY_W +: ENTRY_W];
          laneMask = effMask[LANE_W*ENTRY_W +: ENTRY_W];
        end else begin
          hit      = (strobe.firstEntry >> NARROW_SH) == IDX_W'(e >> NARROW_SH);
          laneData = effData[LANE_N*ENTRY_W +: ENTRY_W];
          laneMask = effMask[LANE_N*ENTRY_W +: ENTRY_W];
        end
      end
      always_ff @(posedge clk) begin
        if (!rstN)                  entryQ <= '0;
        else if (strobe.wrEn && hit) entryQ <= (entryQ & ~laneMask) | (laneData & laneMask);
      end
    end
    assign prioMem[e] = entryQ;
    assign memFlat[e*ENTRY_W +: ENTRY_W] = entryQ;
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdEn) begin
      for (int lane = 0; lane < LANES_WIDE; lane++) begin
        if (strobe.wide || lane < LANES_NARROW)
          rdData[lane*ENTRY_W +: ENTRY_W] = prioMem[strobe.firstEntry + IDX_W'(lane)];
      end
    end
  end

  // R9 / R10: table is frozen whenever control issues no write strobe
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(memFlat));
endmodule

// File: rtl/prio_array_port.sv
module prio_array_port
  import prio_port_pkg::*;
#(
  parameter int SEL_W     = 12,
  parameter int SEL_BASE  = 'h30,
  parameter int EXT_ENTRY = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessEn,
  input  logic [SEL_W-1:0]  selIdx,
  input  logic              wideMode,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] wrMask,
  output logic [WORD_W-1:0] rdData,
  output logic              accessErr
);
  localparam int NUM_WORDS = NUM_ENTRIES / LANES_NARROW;

  prio_strobe_t strobe;

  prio_port_ctrl #(.SEL_W(SEL_W), .SEL_BASE(SEL_BASE), .NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .accessEn(accessEn), .selIdx(selIdx),
    .wideMode(wideMode), .accessErr(accessErr), .strobe(strobe)
  );

  prio_port_dp #(.EXT_ENTRY(EXT_ENTRY)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(wrData), .wrMask(wrMask), .rdData(rdData)
  );

  // R9: flagged access returns zero
  assert_err_rd_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> (rdData == '0));
  // R8: narrow access leaves upper half clear
  assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accessEn && !wideMode) |-> (rdData[WORD_W-1:WORD_W/2] == '0));
  // R10: idle cycle reads zero without error
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !accessEn |-> (rdData == '0 && !accessErr));
endmodule

// File: tb/prio_array_port_tb.sv
module prio_array_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EXT = 11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accessEn = 1'b0;
  logic [11:0] selIdx = '0;
  logic        wideMode = 1'b0;
  logic [63:0] wrData = '0;
  logic [63:0] wrMask = '0;
  logic [63:0] rdData;
  logic        accessErr;

  logic [7:0] model [64];
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_array_port u_dut (
    .clk(clk), .rstN(rstN), .accessEn(accessEn), .selIdx(selIdx),
    .wideMode(wideMode), .wrData(wrData), .wrMask(wrMask),
    .rdData(rdData), .accessErr(accessErr)
  );

  task automatic check(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access: drive after negedge, compare before posedge, update model after it
  task automatic access(input bit en, input logic [11:0] sel, input bit wide,
                        input logic [63:0] data, input logic [63:0] mask, input string req);
    bit          expErr;
    logic [63:0] expRd;
    int          first;
    int          n;
    @(negedge clk);
    accessEn = en; selIdx = sel; wideMode = wide; wrData = data; wrMask = mask;
    #1;
    expErr = en && ((sel < 12'h30) || (sel > 12'h3F) || (wide && sel[0]));
    n = wide ? 8 : 4;
    first = (int'(sel) - 'h30) * 4;
    expRd = '0;
    if (en && !expErr)
      for (int i = 0; i < n; i++) expRd[8*i +: 8] = model[first + i];
    check((rdData === expRd) && (accessErr === expErr), req,
          {accessErr, rdData}, {expErr, expRd});
    @(posedge clk);
    if (en && !expErr)
      for (int i = 0; i < n; i++)
        if (first + i != EXT)
          model[first + i] = (model[first + i] & ~mask[8*i +: 8]) | (data[8*i +: 8] & mask[8*i +: 8]);
  endtask

  task automatic readAll(input string req);
    for (int s = 'h30; s <= 'h3F; s++) access(1, 12'(s), 0, '0, '0, req);
    for (int s = 'h30; s <= 'h3F; s += 2) access(1, 12'(s), 1, '0, '0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: everything zero after reset
    readAll("R1");

    // R4: narrow fill with distinct patterns
    for (int s = 'h30; s <= 'h3F; s++)
      access(1, 12'(s), 0, {32'hDEAD_BEEF, 8'(s), 8'(s + 1), 8'(s + 2), 8'(s + 3)}, '1, "R4");
    readAll("R4");

    // R7: explicit check of the external entry (offset 2, lane 3)
    access(1, 12'h32, 0, 64'hFFFF_FFFF, '1, "R7");
    @(negedge clk); accessEn = 1; selIdx = 12'h32; wideMode = 0; wrMask = '0; #1;
    check(rdData[31:24] === 8'h00, "R7", {57'b0, rdData[31:24]}, '0);
    @(posedge clk);

    // R5: wide writes, full and partial masks
    access(1, 12'h30, 1, 64'h0102_0304_0506_0708, '1, "R5");
    access(1, 12'h3E, 1, 64'h8877_6655_4433_2211, '1, "R5");
    access(1, 12'h32, 1, 64'hA5A5_A5A5_A5A5_A5A5, '1, "R5");
    access(1, 12'h34, 1, 64'h1234_5678_9ABC_DEF0, 64'h00FF_0F0F_F000_FF00, "R6");
    access(1, 12'h34, 1, '0, '0, "R6");
    access(1, 12'h31, 0, '0, '0, "R5");

    // R6: narrow partial mask, read old then new
    access(1, 12'h37, 0, 64'h0000_0000_CAFE_F00D, 64'h0000_0000_FF00_0F0F, "R6");
    access(1, 12'h37, 0, '0, '0, "R6");

    // R8: upper write bits ignored in narrow mode
    access(1, 12'h3A, 0, 64'h7777_7777_1111_1111, 64'hFFFF_FFFF_0000_0000, "R8");
    access(1, 12'h3A, 1, '0, '0, "R8");

    // R2: out of window with write attempt, then readback
    access(1, 12'h2F, 0, '1, '1, "R2");
    access(1, 12'h40, 1, '1, '1, "R2");
    access(1, 12'h000, 0, '1, '1, "R2");
    // R3: odd wide illegal, odd narrow legal
    access(1, 12'h33, 1, '1, '1, "R3");
    access(1, 12'h3F, 1, '1, '1, "R3");
    access(1, 12'h33, 0, '0, '0, "R3");
    // R9: nothing changed by the rejected writes
    readAll("R9");

    // R10: idle cycles with live write data
    access(0, 12'h30, 1, '1, '1, "R10");
    access(0, 12'h3C, 0, '1, '1, "R10");
    readAll("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule